// File: doc/BRIEF.md
# Status-Code Driven I2C Bus Master

This block is a single-master-capable I2C controller that a processor steps one bus event at a time. Software asks for a START, writes an address or data byte, or asks for a STOP through a small register file. Every completed bus event loads an 8-bit status code and raises an interrupt flag. The block then parks the bus, holding SCL low, until software clears the flag. The code tells software what just happened: a START was sent, an address or data byte was acknowledged or not, a byte arrived, or arbitration was lost. Software reads the code and picks the next step.

Both lines are open-drain. The block only ever pulls a line low (`scl_pull`, `sda_pull`) and reads the resolved levels back on `scl_in` and `sda_in`, which are assumed to be synchronous to `clk`. A programmable divider sets the bit rate. Each SCL period takes four divider ticks. Transfers use 7-bit addresses. Bit 0 of the address byte selects read (1) or write (0).

Top module: `i2c_step_master`

## Requirements
- R1: Register map by address: 0 = data byte, 1 = control {bit3 flag, bit2 start request, bit1 stop request, bit0 acknowledge-enable}, 2 = status code (read only), 3 = clock divider. After reset the status reads F8h, control reads 00h, `irq` is 0 and neither line is pulled. The divider reads back the value written to it.
- R2: With the start request set and the flag clear, and the bus free, the block issues a START condition. It then loads code 08h, sets the flag and clears the start request.
- R3: While the flag is set (other than after code 38h), SCL is held low and no bit is shifted. An address written to the data register goes out only after software clears the flag.
- R4: After an address byte with bit 0 = 0, the code is 18h if the slave acknowledged and 20h if it did not.
- R5: After a transmitted data byte, the code is 28h on acknowledge and 30h on no acknowledge. The flag is set in both cases.
- R6: After an address byte with bit 0 = 1, the code is 40h on acknowledge and 48h on no acknowledge. No data bit is received before that code is reported.
- R7: In receive, a byte is shifted in MSB first and placed in the data register. The block answers with ACK (SDA low) when acknowledge-enable is 1 and reports 50h. It answers with NACK when acknowledge-enable is 0 and reports 58h.
- R8: Setting the start request while the bus is owned and then clearing the flag sends a repeated START and reports 10h.
- R9: Setting the stop request and clearing the flag sends a STOP condition. The block clears the stop request itself, loads F8h, leaves the flag clear and releases both lines.
- R10: Setting both requests and clearing the flag sends a STOP, then a fresh START, and reports 08h.
- R11: If the block releases SDA for a 1 bit but reads SDA low while SCL is high, it reports 38h, sets the flag and releases both lines.
- R12: After 38h, clearing the flag alone returns the block to idle (F8h, flag clear). Clearing it with the start request set makes the block wait until a STOP is seen on the bus, then issue a START and report 08h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Event flag, high while software owes a response |
| scl_in | input | 1 | Resolved SCL level |
| sda_in | input | 1 | Resolved SDA level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |

## Verification
A wrong engine state nearly always shows up at the next flag as a wrong status code, or as a flag that never rises and stalls the step sequence. A behavioural slave on the wired bus therefore exposes most faults within one byte time. A receive fault shows as a wrong data byte or a wrong 50h/58h choice at the end of that byte. A fault in the hold or release logic shows within a divider tick as SCL moving while the flag is set, or as a line still pulled after a STOP or a lost arbitration. Bus-free tracking is observed by holding SDA low from outside and confirming that no START and no flag appear until the line is released.

// File: rtl/i2c_step_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the stepped I2C master: status codes, engine
// states and the decoding of which status code leads to which step.
package i2c_step_pkg;

    localparam logic [7:0] CODE_START  = 8'h08;
    localparam logic [7:0] CODE_RSTART = 8'h10;
    localparam logic [7:0] CODE_WA_ACK = 8'h18;
    localparam logic [7:0] CODE_WA_NAK = 8'h20;
    localparam logic [7:0] CODE_TX_ACK = 8'h28;
    localparam logic [7:0] CODE_TX_NAK = 8'h30;
    localparam logic [7:0] CODE_LOST   = 8'h38;
    localparam logic [7:0] CODE_RA_ACK = 8'h40;
    localparam logic [7:0] CODE_RA_NAK = 8'h48;
    localparam logic [7:0] CODE_RX_ACK = 8'h50;
    localparam logic [7:0] CODE_RX_NAK = 8'h58;
    localparam logic [7:0] CODE_IDLE   = 8'hF8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_BIT, ST_STOP, ST_HOLD
    } eng_state_e;

    // True when the byte that follows this code is received, not sent.
    function automatic logic code_is_rx(input logic [7:0] code);
        return (code == CODE_RA_ACK) || (code == CODE_RA_NAK) ||
               (code == CODE_RX_ACK) || (code == CODE_RX_NAK);
    endfunction

    // True when the byte that follows this code is an address byte.
    function automatic logic code_is_addr(input logic [7:0] code);
        return (code == CODE_START) || (code == CODE_RSTART);
    endfunction

    // Code reported when a byte and its acknowledge bit have finished.
    function automatic logic [7:0] byte_code(input logic rx, input logic addr,
                                             input logic rd, input logic ack_in,
                                             input logic ack_out);
        if (rx)
            return ack_out ? CODE_RX_ACK : CODE_RX_NAK;
        else if (addr && rd)
            return ack_in ? CODE_RA_ACK : CODE_RA_NAK;
        else if (addr)
            return ack_in ? CODE_WA_ACK : CODE_WA_NAK;
        else
            return ack_in ? CODE_TX_ACK : CODE_TX_NAK;
    endfunction

endpackage

// File: rtl/i2c_step_tick.sv
`timescale 1ns/1ps
// Bit-rate divider: raises tick for one clock every (div + 1) clocks.
// Assumes div may change at any time; the new value takes effect at the
// next reload.
module i2c_step_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == '0);

    // Count down, reload from the divider on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= div;
        else
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/i2c_step_busmon.sv
`timescale 1ns/1ps
// Bus activity monitor: marks the bus busy from any START seen on the
// lines until a STOP is seen. Assumes synchronous line inputs.
module i2c_step_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic busy
);
    logic scl_q, sda_q;
    logic start_seen, stop_seen;

    assign start_seen = scl_q && scl_in && sda_q && !sda_in;
    assign stop_seen  = scl_q && scl_in && !sda_q && sda_in;

    // Keep the previous line levels and the busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            busy  <= 1'b0;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
            if (start_seen)
                busy <= 1'b1;
            else if (stop_seen)
                busy <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_step_engine.sv
`timescale 1ns/1ps
// Bit engine: creates START, byte and STOP sequences on the open-drain
// lines, four ticks per SCL period (low, low, high, high). It reports each
// finished step as a one-cycle event and then waits in ST_HOLD until the
// flag is clear. Assumes the register file applies an event on the next
// edge, which is why ST_HOLD skips its first cycle.
module i2c_step_engine
    import i2c_step_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       iflg,
    input  logic       sta,
    input  logic       stp,
    input  logic       aak,
    input  logic       bus_busy,
    input  logic [7:0] tx_byte,
    input  logic [7:0] cur_code,
    input  logic       sda_in,
    output logic       scl_pull,
    output logic       sda_pull,
    output logic       ev_valid,
    output logic       ev_flag,
    output logic       ev_rx,
    output logic       clr_sta,
    output logic       clr_stp,
    output logic [7:0] ev_code,
    output logic [7:0] rx_byte
);
    eng_state_e state;
    logic [1:0] ph;
    logic [3:0] bcnt;
    logic [7:0] shreg;
    logic       is_rx, is_addr, rd_dir, owner, ack_in, ack_out, hold_arm;

    assign rx_byte = shreg;

    // Sequence all bus activity and report the outcome of each step.
    always_ff @(posedge clk) begin
        ev_valid <= 1'b0;
        ev_flag  <= 1'b0;
        ev_rx    <= 1'b0;
        clr_sta  <= 1'b0;
        clr_stp  <= 1'b0;
        if (!rst_n) begin
            state    <= ST_IDLE;
            ph       <= 2'd0;
            bcnt     <= 4'd0;
            shreg    <= 8'd0;
            is_rx    <= 1'b0;
            is_addr  <= 1'b0;
            rd_dir   <= 1'b0;
            owner    <= 1'b0;
            ack_in   <= 1'b0;
            ack_out  <= 1'b0;
            hold_arm <= 1'b0;
            scl_pull <= 1'b0;
            sda_pull <= 1'b0;
            ev_code  <= CODE_IDLE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (sta && !iflg && !bus_busy) begin
                        state <= ST_START;
                        ph    <= 2'd0;
                    end
                end
                ST_START: if (tick) begin
                    ph <= ph + 2'd1;
                    case (ph)
                        2'd0: sda_pull <= 1'b0;
                        2'd1: scl_pull <= 1'b0;
                        2'd2: sda_pull <= 1'b1;
                        default: begin
                            scl_pull <= 1'b1;
                            state    <= ST_HOLD;
                            hold_arm <= 1'b0;
                            ev_valid <= 1'b1;
                            ev_flag  <= 1'b1;
                            ev_code  <= owner ? CODE_RSTART : CODE_START;
                            clr_sta  <= 1'b1;
                            owner    <= 1'b1;
                        end
                    endcase
                end
                ST_HOLD: begin
                    hold_arm <= 1'b1;
                    if (hold_arm && !iflg) begin
                        ph <= 2'd0;
                        if (cur_code == CODE_LOST) begin
                            state    <= ST_IDLE;
                            ev_valid <= 1'b1;
                            ev_code  <= CODE_IDLE;
                        end else if (stp) begin
                            state <= ST_STOP;
                        end else if (sta) begin
                            state <= ST_START;
                        end else begin
                            state   <= ST_BIT;
                            bcnt    <= 4'd0;
                            shreg   <= tx_byte;
                            is_rx   <= code_is_rx(cur_code);
                            is_addr <= code_is_addr(cur_code);
                            if (code_is_addr(cur_code))
                                rd_dir <= tx_byte[0];
                        end
                    end
                end
                ST_BIT: if (tick) begin
                    ph <= ph + 2'd1;
                    case (ph)
                        2'd0: begin
                            if (bcnt == 4'd8) begin
                                sda_pull <= is_rx && aak;
                                ack_out  <= aak;
                            end else begin
                                sda_pull <= !is_rx && !shreg[7];
                            end
                        end
                        2'd1: scl_pull <= 1'b0;
                        2'd2: begin
                            if (bcnt == 4'd8) begin
                                ack_in <= !sda_in;
                            end else if (!is_rx && !sda_pull && !sda_in) begin
                                state    <= ST_HOLD;
                                hold_arm <= 1'b0;
                                scl_pull <= 1'b0;
                                sda_pull <= 1'b0;
                                owner    <= 1'b0;
                                ev_valid <= 1'b1;
                                ev_flag  <= 1'b1;
                                ev_code  <= CODE_LOST;
                            end else begin
                                shreg <= {shreg[6:0], sda_in};
                            end
                        end
                        default: begin
                            scl_pull <= 1'b1;
                            if (bcnt == 4'd8) begin
                                state    <= ST_HOLD;
                                hold_arm <= 1'b0;
                                ev_valid <= 1'b1;
                                ev_flag  <= 1'b1;
                                ev_rx    <= is_rx;
                                ev_code  <= byte_code(is_rx, is_addr, rd_dir, ack_in, ack_out);
                            end else begin
                                bcnt <= bcnt + 4'd1;
                            end
                        end
                    endcase
                end
                ST_STOP: if (tick) begin
                    ph <= ph + 2'd1;
                    case (ph)
                        2'd0: sda_pull <= 1'b1;
                        2'd1: scl_pull <= 1'b0;
                        2'd2: sda_pull <= 1'b0;
                        default: begin
                            owner    <= 1'b0;
                            clr_stp  <= 1'b1;
                            ev_valid <= 1'b1;
                            ev_code  <= CODE_IDLE;
                            state    <= sta ? ST_START : ST_IDLE;
                        end
                    endcase
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_step_master.sv
`timescale 1ns/1ps
// Stepped I2C master top: register file (data, control, status, divider)
// plus the divider, bus monitor and bit engine. Software answers every
// flagged status code before the bus moves on. Assumes synchronous line
// inputs and no clock stretching by slaves.
module i2c_step_master
    import i2c_step_pkg::*;
#(
    parameter int         DIV_W     = 8,
    parameter logic [7:0] DIV_RESET = 8'd49
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_waddr,
    input  logic [7:0] reg_wdata,
    input  logic [1:0] reg_raddr,
    output logic [7:0] reg_rdata,
    output logic       irq,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_pull,
    output logic       sda_pull
);
    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_DIV  = 2'd3;
    localparam int         B_AAK  = 0;
    localparam int         B_STP  = 1;
    localparam int         B_STA  = 2;
    localparam int         B_FLG  = 3;

    logic [7:0]       data_q, status_q;
    logic [DIV_W-1:0] div_q;
    logic             iflg, sta, stp, aak;
    logic             tick, busy;
    logic             ev_valid, ev_flag, ev_rx, clr_sta, clr_stp;
    logic [7:0]       ev_code, rx_byte;
    logic             ctrl_wr;

    assign ctrl_wr = reg_wr && (reg_waddr == A_CTRL);
    assign irq     = iflg;

    // Register file: software writes first, engine events take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= 8'd0;
            status_q <= CODE_IDLE;
            div_q    <= DIV_W'(DIV_RESET);
            iflg     <= 1'b0;
            sta      <= 1'b0;
            stp      <= 1'b0;
            aak      <= 1'b0;
        end else begin
            if (clr_sta) sta <= 1'b0;
            if (clr_stp) stp <= 1'b0;
            if (reg_wr && reg_waddr == A_DATA) data_q <= reg_wdata;
            if (reg_wr && reg_waddr == A_DIV)  div_q  <= DIV_W'(reg_wdata);
            if (ctrl_wr) begin
                sta <= reg_wdata[B_STA];
                stp <= reg_wdata[B_STP];
                aak <= reg_wdata[B_AAK];
                if (!reg_wdata[B_FLG]) iflg <= 1'b0;
            end
            if (ev_valid) status_q <= ev_code;
            if (ev_flag)  iflg     <= 1'b1;
            if (ev_rx)    data_q   <= rx_byte;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_raddr)
            A_DATA:  reg_rdata = data_q;
            A_CTRL:  reg_rdata = {4'd0, iflg, sta, stp, aak};
            A_STAT:  reg_rdata = status_q;
            default: reg_rdata = 8'(div_q);
        endcase
    end

    i2c_step_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
    );

    i2c_step_busmon u_busmon (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .busy(busy)
    );

    i2c_step_engine u_engine (
        .clk(clk), .rst_n(rst_n), .tick(tick), .iflg(iflg), .sta(sta),
        .stp(stp), .aak(aak), .bus_busy(busy), .tx_byte(data_q),
        .cur_code(status_q), .sda_in(sda_in), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .ev_valid(ev_valid), .ev_flag(ev_flag),
        .ev_rx(ev_rx), .clr_sta(clr_sta), .clr_stp(clr_stp),
        .ev_code(ev_code), .rx_byte(rx_byte)
    );

    AST_START_LEAVES_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(iflg) && status_q == CODE_START) |-> (scl_pull && sda_pull)); // R2
    AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (iflg && status_q != CODE_LOST) |-> scl_pull); // R3
    AST_LOST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (iflg && status_q == CODE_LOST) |-> (!scl_pull && !sda_pull)); // R11
    AST_STOP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stp) && !$past(ctrl_wr)) |-> (status_q == CODE_IDLE && !iflg)); // R9
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == CODE_IDLE && !sta && !iflg) |-> (!scl_pull && !sda_pull)); // R9
endmodule

// File: tb/i2c_step_master_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver steps the master and queues the expected
// status codes; a monitor pops them as the flag rises and compares.
module i2c_step_master_tb;
    localparam int         CLK_PERIOD = 10;
    localparam logic [6:0] SADDR      = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_waddr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [1:0] reg_raddr = 2'd2;
    logic [7:0] reg_rdata;
    logic       irq, scl_pull, sda_pull;
    logic       slv_lo = 1'b0;
    logic       force_lo = 1'b0;
    wire        scl_bus = !scl_pull;
    wire        sda_bus = !(sda_pull || slv_lo || force_lo);

    int n_chk = 0;
    int n_fail = 0;
    int stop_cnt = 0;

    logic [7:0] q_code[$];
    logic       q_irq[$];
    logic       q_dchk[$];
    logic [7:0] q_data[$];
    string      q_req[$];

    always #(CLK_PERIOD/2) clk = !clk;

    i2c_step_master #(.DIV_W(8), .DIV_RESET(8'd49)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .irq(irq), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Behavioural slave at address SADDR; NACKs data byte EEh, sends C5h then 3Ah.
    logic       p_scl = 1'b1, p_sda = 1'b1;
    logic [2:0] sph = 3'd0;
    logic [3:0] bitc = 4'd0;
    logic [7:0] sh = 8'd0, tb_byte = 8'd0;
    logic       ridx = 1'b0;
    always @(negedge clk) begin
        p_scl <= scl_bus;
        p_sda <= sda_bus;
        if (p_scl && scl_bus && p_sda && !sda_bus) begin
            sph <= 3'd1; bitc <= 4'd0; slv_lo <= 1'b0; ridx <= 1'b0;
        end else if (p_scl && scl_bus && !p_sda && sda_bus) begin
            sph <= 3'd0; slv_lo <= 1'b0; stop_cnt <= stop_cnt + 1;
        end else if (sph != 3'd0) begin
            if (!p_scl && scl_bus) begin
                if (bitc < 4'd8 && sph != 3'd3) sh <= {sh[6:0], sda_bus};
                if (bitc == 4'd8 && sph == 3'd3 && sda_bus) sph <= 3'd4;
                bitc <= bitc + 4'd1;
            end else if (p_scl && !scl_bus) begin
                if (bitc == 4'd8) begin
                    if (sph == 3'd1)      slv_lo <= (sh[7:1] == SADDR);
                    else if (sph == 3'd2) slv_lo <= (sh != 8'hEE);
                    else                  slv_lo <= 1'b0;
                end else if (bitc == 4'd9) begin
                    bitc <= 4'd0;
                    slv_lo <= 1'b0;
                    if (sph == 3'd1) begin
                        if (sh[7:1] != SADDR) sph <= 3'd4;
                        else if (!sh[0]) sph <= 3'd2;
                        else begin
                            sph <= 3'd3; tb_byte <= 8'hC5; slv_lo <= !1'b1; ridx <= 1'b1;
                        end
                    end else if (sph == 3'd3) begin
                        tb_byte <= ridx ? 8'h3A : 8'hC5;
                        slv_lo  <= ridx ? 1'b1 : 1'b0;
                        ridx    <= !ridx;
                    end
                end else if (sph == 3'd3 && bitc >= 4'd1 && bitc <= 4'd7) begin
                    slv_lo <= !tb_byte[4'd7 - bitc];
                end
            end
        end
    end

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic expect_ev(input logic [7:0] code, input logic flg, input logic dchk,
                             input logic [7:0] d, input string req);
        q_code.push_back(code); q_irq.push_back(flg);
        q_dchk.push_back(dchk); q_data.push_back(d); q_req.push_back(req);
    endtask

    task automatic drain();
        while (q_code.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: waits for each expected event and compares status/data.
    initial begin
        forever begin
            @(negedge clk);
            if (q_code.size() != 0) begin
                int wt = 0;
                if (q_irq[0]) begin
                    while (!irq && wt < 5000) begin @(negedge clk); wt++; end
                end else begin
                    repeat (80) @(negedge clk);
                end
                reg_raddr = 2'd2; #1;
                chk(q_req[0], reg_rdata, q_code[0]);
                chk({q_req[0], " flag"}, {7'd0, irq}, {7'd0, q_irq[0]});
                if (q_dchk[0]) begin
                    reg_raddr = 2'd0; #1;
                    chk({q_req[0], " data"}, reg_rdata, q_data[0]);
                end
                if (!q_irq[0]) begin
                    reg_raddr = 2'd1; #1;
                    chk({q_req[0], " stp cleared"}, {7'd0, reg_rdata[1]}, 8'd0);
                end
                reg_raddr = 2'd2;
                void'(q_code.pop_front()); void'(q_irq.pop_front());
                void'(q_dchk.pop_front()); void'(q_data.pop_front());
                void'(q_req.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int stops_before;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reg_raddr = 2'd2; #1; chk("R1 reset status", reg_rdata, 8'hF8);
        reg_raddr = 2'd1; #1; chk("R1 reset control", reg_rdata, 8'h00);
        chk("R1 reset irq", {7'd0, irq}, 8'd0);
        chk("R1 reset lines", {6'd0, scl_pull, sda_pull}, 8'd0);
        wreg(2'd3, 8'd3);
        reg_raddr = 2'd3; #1; chk("R1 divider readback", reg_rdata, 8'd3);
        reg_raddr = 2'd2;

        // Write transfer: START, address, two data bytes.
        wreg(2'd1, 8'h04); expect_ev(8'h08, 1, 0, 0, "R2 start"); drain();
        wreg(2'd0, {SADDR, 1'b0});
        repeat (100) @(negedge clk);
        chk("R3 scl held", {7'd0, scl_bus}, 8'd0);
        reg_raddr = 2'd2; #1; chk("R3 no progress", reg_rdata, 8'h08);
        wreg(2'd1, 8'h00); expect_ev(8'h18, 1, 0, 0, "R4 write addr ack"); drain();
        wreg(2'd0, 8'h11); wreg(2'd1, 8'h00); expect_ev(8'h28, 1, 0, 0, "R5 data ack"); drain();
        wreg(2'd0, 8'hEE); wreg(2'd1, 8'h00); expect_ev(8'h30, 1, 0, 0, "R5 data nack"); drain();

        // Repeated START into a read of two bytes.
        wreg(2'd1, 8'h04); expect_ev(8'h10, 1, 0, 0, "R8 repeated start"); drain();
        wreg(2'd0, {SADDR, 1'b1}); wreg(2'd1, 8'h00); expect_ev(8'h40, 1, 0, 0, "R6 read addr ack"); drain();
        wreg(2'd1, 8'h01); expect_ev(8'h50, 1, 1, 8'hC5, "R7 rx ack"); drain();
        wreg(2'd1, 8'h00); expect_ev(8'h58, 1, 1, 8'h3A, "R7 rx nack"); drain();

        // STOP then START, unanswered address, plain STOP.
        wreg(2'd1, 8'h06); expect_ev(8'h08, 1, 0, 0, "R10 stop+start"); drain();
        wreg(2'd0, 8'h30); wreg(2'd1, 8'h00); expect_ev(8'h20, 1, 0, 0, "R4 write addr nack"); drain();
        stops_before = stop_cnt;
        wreg(2'd1, 8'h02); expect_ev(8'hF8, 0, 0, 0, "R9 stop"); drain();
        chk("R9 stop on bus", 8'(stop_cnt - stops_before), 8'd1);
        chk("R9 lines released", {6'd0, scl_pull, sda_pull}, 8'd0);

        // Arbitration loss, then clear only.
        wreg(2'd1, 8'h04); expect_ev(8'h08, 1, 0, 0, "R2 start again"); drain();
        force_lo = 1'b1;
        wreg(2'd0, 8'hA4); wreg(2'd1, 8'h00); expect_ev(8'h38, 1, 0, 0, "R11 lost"); drain();
        chk("R11 lines released", {6'd0, scl_pull, sda_pull}, 8'd0);
        wreg(2'd1, 8'h00); expect_ev(8'hF8, 0, 0, 0, "R12 clear to idle"); drain();
        force_lo = 1'b0;
        repeat (20) @(negedge clk);

        // Arbitration loss, then START request while the bus is still busy.
        wreg(2'd1, 8'h04); expect_ev(8'h08, 1, 0, 0, "R2 start third"); drain();
        force_lo = 1'b1;
        wreg(2'd0, 8'hA4); wreg(2'd1, 8'h00); expect_ev(8'h38, 1, 0, 0, "R11 lost again"); drain();
        wreg(2'd1, 8'h04);
        repeat (200) @(negedge clk);
        chk("R12 waits for free bus irq", {7'd0, irq}, 8'd0);
        reg_raddr = 2'd2; #1; chk("R12 waits for free bus status", reg_rdata, 8'hF8);
        chk("R12 no start while busy", {6'd0, scl_pull, sda_pull}, 8'd0);
        expect_ev(8'h08, 1, 0, 0, "R12 start after free");
        force_lo = 1'b0;
        drain();
        wreg(2'd1, 8'h02); expect_ev(8'hF8, 0, 0, 0, "R9 final stop"); drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule